// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block decides, for each of the two ALU source operands of an instruction in the execute stage, where the operand value should come from. The value can come from the register file read. It can also come from the result held one stage ahead, in the memory stage. A third choice is the result held two stages ahead, in the write-back stage. The block compares the two source register numbers against the destination numbers and write enables of the two later stages. It produces a 2-bit select for each operand.

The selects also drive a pair of operand multiplexers inside the block, so the caller gets the resolved operands directly. The block is purely combinational and holds no state. The register file writes in the first half of a cycle and reads in the second half. A write-back result therefore already reaches a decode-stage read, and the block needs only the two forwarding paths. Register number zero is hard-wired and is never forwarded.

Top module: `fwd_unit`

## Requirements
- R1: A select is 2'b10 (memory-stage result) when the memory-stage write enable is 1, the memory-stage destination is nonzero and it equals that operand's source register.
- R2: A select is 2'b01 (write-back-stage result) when the write-back-stage write enable is 1, its destination is nonzero and equal to the source register, and the R1 condition does not hold for that operand.
- R3: When both later stages qualify for the same source register, the memory-stage result (2'b10) wins over the older write-back-stage result.
- R4: A source register number of 0 always gives select 2'b00, whatever the destinations and enables; a memory-stage destination of 0 never blocks a write-back forward.
- R5: With no forwarding condition met, including matches whose write enable is 0, the select is 2'b00 (register file value).
- R6: The code 2'b11 never appears on either select.
- R7: Each operand output equals the register file value under select 00, the memory-stage result under 10 and the write-back-stage result under 01.
- R8: Operand A is resolved from the first source register (`src_a`) and operand B from the second (`src_b`), each independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | RW | First source register number in execute stage |
| src_b | input | RW | Second source register number in execute stage |
| mem_rd | input | RW | Memory-stage destination register number |
| mem_we | input | 1 | Memory-stage register write enable |
| wb_rd | input | RW | Write-back-stage destination register number |
| wb_we | input | 1 | Write-back-stage register write enable |
| rf_a | input | DW | Register file value for operand A |
| rf_b | input | DW | Register file value for operand B |
| mem_res | input | DW | Result held in the memory stage |
| wb_res | input | DW | Result held in the write-back stage |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DW | Resolved operand A |
| opnd_b | output | DW | Resolved operand B |

## Verification
The assertions assume that every input carries a known 0 or 1 value whenever they are evaluated, because the block is sampled as pure logic with no reset to mask start-up. They also assume the destination fields are meaningful only together with their write enables. The stimulus sets every input to a defined value before the first check. It changes inputs only on the falling clock edge and looks at the outputs a little later. It sweeps all register numbers, zero included, with the enables both on and off.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [DW-1:0] mem_res,
  input  logic [DW-1:0] wb_res,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [RW-1:0] ZERO = '0;

  logic mem_live, wb_live;
  assign mem_live = mem_we && (mem_rd != ZERO);
  assign wb_live  = wb_we  && (wb_rd  != ZERO);

  function automatic logic [1:0] pick(input logic [RW-1:0] src,
                                      input logic m_live, input logic [RW-1:0] m_rd,
                                      input logic w_live, input logic [RW-1:0] w_rd);
    if (m_live && (m_rd == src))      return SEL_MEM;
    else if (w_live && (w_rd == src)) return SEL_WB;
    else                              return SEL_RF;
  endfunction

  function automatic logic [DW-1:0] route(input logic [1:0] s, input logic [DW-1:0] rf,
                                          input logic [DW-1:0] m, input logic [DW-1:0] w);
    case (s)
      SEL_MEM: return m;
      SEL_WB:  return w;
      default: return rf;
    endcase
  endfunction

  assign sel_a  = pick(src_a, mem_live, mem_rd, wb_live, wb_rd);
  assign sel_b  = pick(src_b, mem_live, mem_rd, wb_live, wb_rd);
  assign opnd_a = route(sel_a, rf_a, mem_res, wb_res);
  assign opnd_b = route(sel_b, rf_b, mem_res, wb_res);
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input logic [RW-1:0] src_a,
  input logic [RW-1:0] src_b,
  input logic [RW-1:0] mem_rd,
  input logic          mem_we,
  input logic [RW-1:0] wb_rd,
  input logic          wb_we,
  input logic [DW-1:0] rf_a,
  input logic [DW-1:0] rf_b,
  input logic [DW-1:0] mem_res,
  input logic [DW-1:0] wb_res,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b
);
  always_comb begin
    p_mem_source_r1: assert (sel_a != 2'b10 || (mem_we && mem_rd == src_a && src_a != '0))
      else $error("sel_a 10 without qualifying memory stage");
    p_wb_source_r2: assert (sel_b != 2'b01 || (wb_we && wb_rd == src_b && src_b != '0))
      else $error("sel_b 01 without qualifying write-back stage");
    p_newer_wins_r3: assert (!(mem_we && mem_rd == src_a && src_a != '0) || sel_a == 2'b10)
      else $error("memory-stage match not preferred");
    p_zero_reg_r4: assert (src_a != '0 || sel_a == 2'b00)
      else $error("register zero forwarded on A");
    p_no_code3_r6: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("select code 11 produced");
    p_mux_rf_r7: assert (sel_b != 2'b00 || opnd_b == rf_b)
      else $error("operand B not register file value");
    p_mux_wb_r7: assert (sel_a != 2'b01 || opnd_a == wb_res)
      else $error("operand A not write-back value");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.RW(RW), .DW(DW)) u_chk (.*);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [RW-1:0] src_a, src_b, mem_rd, wb_rd;
  logic          mem_we, wb_we;
  logic [DW-1:0] rf_a, rf_b, mem_res, wb_res;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  fwd_unit #(.RW(RW), .DW(DW)) dut (
    .src_a(src_a), .src_b(src_b), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .rf_a(rf_a), .rf_b(rf_b),
    .mem_res(mem_res), .wb_res(wb_res), .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b));

  task automatic drive(input int a, input int b, input int m, input bit mw,
                       input int w, input bit ww);
    @(negedge clk);
    src_a = RW'(a); src_b = RW'(b); mem_rd = RW'(m); mem_we = mw;
    wb_rd = RW'(w); wb_we = ww;
    #2;
  endtask

  function automatic logic [DW-1:0] want_op(input logic [1:0] s, input logic [DW-1:0] rf);
    return (s == 2'b10) ? mem_res : (s == 2'b01) ? wb_res : rf;
  endfunction

  task automatic check(input string req, input logic [1:0] ea, input logic [1:0] eb);
    n_run++;
    if (sel_a !== ea || sel_b !== eb) begin
      n_fail++;
      $display("FAIL %s sel a/b=%b/%b expected %b/%b", req, sel_a, sel_b, ea, eb);
    end
    n_run++;
    if (opnd_a !== want_op(ea, rf_a) || opnd_b !== want_op(eb, rf_b)) begin
      n_fail++;
      $display("FAIL %s/R7 opnd a/b=%h/%h expected %h/%h", req, opnd_a, opnd_b,
               want_op(ea, rf_a), want_op(eb, rf_b));
    end
  endtask

  task automatic t_idle;      drive(0,0,0,0,0,0);   check("R5", 2'b00, 2'b00); endtask
  task automatic t_mem_fwd;   drive(3,4,3,1,0,0);   check("R1", 2'b10, 2'b00); endtask
  task automatic t_wb_fwd;    drive(6,7,0,0,7,1);   check("R2", 2'b00, 2'b01); endtask
  task automatic t_newer;     drive(9,9,9,1,9,1);   check("R3", 2'b10, 2'b10); endtask
  task automatic t_mem_off;   drive(9,9,9,0,9,1);   check("R2", 2'b01, 2'b01); endtask
  task automatic t_enables;   drive(12,13,12,0,13,0); check("R5", 2'b00, 2'b00); endtask
  task automatic t_split;     drive(5,6,5,1,6,1);   check("R8", 2'b10, 2'b01); endtask
  task automatic t_split_rev; drive(6,5,5,1,6,1);   check("R8", 2'b01, 2'b10); endtask
  task automatic t_zero_src;  drive(0,0,0,1,0,1);   check("R4", 2'b00, 2'b00); endtask
  task automatic t_zero_mem;  drive(5,0,0,1,5,1);   check("R4", 2'b01, 2'b00); endtask

  task automatic t_sweep;
    for (int r = 0; r < (1 << RW); r++) begin
      drive(r, r, r, 1, r, 1);
      check("R3", (r == 0) ? 2'b00 : 2'b10, (r == 0) ? 2'b00 : 2'b10);
      drive(r, (r + 1) % (1 << RW), 0, 0, r, 1);
      check("R2", (r == 0) ? 2'b00 : 2'b01, 2'b00);
      n_run++;
      if (sel_a === 2'b11 || sel_b === 2'b11) begin
        n_fail++;
        $display("FAIL R6 sel a/b=%b/%b expected not 11", sel_a, sel_b);
      end
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    src_a = '0; src_b = '0; mem_rd = '0; wb_rd = '0; mem_we = 0; wb_we = 0;
    rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002;
    mem_res = 32'hCCCC_0003; wb_res = 32'hDDDD_0004;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_idle;
    t_mem_fwd;
    t_wb_fwd;
    t_newer;
    t_mem_off;
    t_enables;
    t_split;
    t_split_rev;
    t_zero_src;
    t_zero_mem;
    t_sweep;
    finish_run;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run;
  end
endmodule